// File: doc/BRIEF.md
# Shared-Bus Converter Round-Robin Sequencer

This block runs a set of up to ten analog-to-digital converters that share one tri-state data bus. Each converter has its own active-low select line. Pulling the line low starts a conversion. Releasing it blanks that converter's outputs, and its data-ready output returns high a short time later. The data-ready outputs are open-drain and are wired together into two groups. The sequencer reads only the group line of the channel it currently has selected.

The sequencer visits the channels in a fixed rotation. When the selected converter reports completion, the sequencer selects the next converter straight away, so that conversion is already running while the finished result is still on the bus. After a fixed capture delay it samples the bus and releases the finished converter. That release falls well inside the clear deadline the converters need before the next result can appear.

Each result goes out on a one-cycle strobe and is stored in a per-channel register file that has a valid flag and an error flag. A converter that never reports completion is given up after a timeout. It is recorded as an error, and the rotation continues.

Top module: `mcs_seq`

## Requirements
- R1: After reset every select line is high, no result strobe is issued, and every channel reads back with both its valid flag and its error flag clear.
- R2: At most two select lines are low at once. Two are low only during the overlap window, and at any moment at most one converter drives the shared bus.
- R3: Channels are served in ascending order 0, 1, …, NUM_CH-1, after which the order wraps to 0.
- R4: When the selected channel's completion is seen and `enable` is high, the next channel's select line goes low in the same cycle. The finished channel is released exactly CAP_DLY+1 cycles later, a span that stays below CLEAR_DL cycles.
- R5: Completion is taken from group status bit 0 for channels 0 to GRP0_SIZE-1 and from bit 1 for the remaining channels. The status passes through SYNC_STAGES flops first. A low level counts only after that group line has been seen high during the current selection.
- R6: A completed channel produces a strobe with `res_err`=0, its channel number, and the bus value sampled CAP_DLY+1 cycles after completion was seen.
- R7: A channel with no completion is released after being selected for exactly TIMEOUT cycles. It produces a strobe with `res_err`=1 and `res_data`=0, and the next channel starts in the same cycle with no overlap.
- R8: With `enable` low, the conversion in progress still finishes and reports, after which all select lines stay high and no further strobes appear. When `enable` is raised again, service resumes at the channel after the last one served.
- R9: The register file shows `rd_data`, `rd_valid` and `rd_err` for the channel `rd_ch` one clock after `rd_ch` is applied. A success sets the valid flag, stores the data and clears the error flag. A timeout sets the error flag and clears the valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows new conversions to be started |
| grp_rdy_n | input | 2 | Wire-ORed data-ready per group, low = done |
| bus_data | input | DATA_W | Shared converter data bus |
| sel_n | output | NUM_CH | Active-low select/convert line per converter |
| res_stb | output | 1 | One-cycle result strobe |
| res_ch | output | CH_W | Channel of the current result |
| res_data | output | DATA_W | Captured data (0 on timeout) |
| res_err | output | 1 | Result is a timeout |
| rd_ch | input | CH_W | Register file read index |
| rd_data | output | DATA_W | Stored data of `rd_ch` |
| rd_valid | output | 1 | Stored data of `rd_ch` is valid |
| rd_err | output | 1 | Last visit of `rd_ch` timed out |

## Verification
A converter's data-ready edge reaches the control logic SYNC_STAGES cycles after it occurs. The result strobe follows CAP_DLY+1 cycles after that. The scoreboard monitor compares every strobe against the next expected item at the falling edge that follows it, so it never depends on the exact arrival cycle. Timing itself is checked by counting cycles on the select lines at falling edges: the run of two-low cycles must be exactly CAP_DLY+1 long, and a silent channel must stay selected for exactly TIMEOUT cycles. Register file reads are sampled one full cycle after `rd_ch` changes, matching the single registered read stage.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_OVL  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/mcs_sync.sv
module mcs_sync #(
  parameter int W       = 2,
  parameter int STAGES  = 2,
  parameter logic RST_V = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES <= 1) begin : g_one
      logic [W-1:0] s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= {W{RST_V}};
        else     s_q <= d;
      end
      assign q = s_q;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= {(STAGES*W){RST_V}};
        else     s_q <= {s_q[STAGES-2:0], d};
      end
      assign q = s_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
  import mcs_pkg::*;
#(
  parameter int NUM_CH    = 10,
  parameter int DATA_W    = 8,
  parameter int GRP0_SIZE = 6,
  parameter int TIMEOUT   = 200,
  parameter int CAP_DLY   = 30,
  parameter int CLEAR_DL  = 750,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [1:0]        grp_s,
  input  logic [DATA_W-1:0] bus_data,
  output logic [NUM_CH-1:0] sel_n,
  output logic              res_stb,
  output logic [CH_W-1:0]   res_ch,
  output logic [DATA_W-1:0] res_data,
  output logic              res_err
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam int OC_W  = $clog2(CAP_DLY + 2);
  localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);
  localparam logic [CH_W-1:0]  G0_END   = CH_W'(GRP0_SIZE);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT - 1);
  localparam logic [CNT_W-1:0] CNT_OVL  = CNT_W'(CAP_DLY + 1);
  localparam logic [OC_W-1:0]  CAP_LAST = OC_W'(CAP_DLY);

  seq_st_e           state_q;
  logic [CH_W-1:0]   cur_q, ptr_q;
  logic              go_q, armed_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [OC_W-1:0]   oc_q;
  logic [NUM_CH-1:0] sel_n_q;

  logic [CH_W-1:0] nxt_ch;
  logic            stat, done_w, tmo_w;

  always_comb begin
    nxt_ch = (cur_q == LAST_CH) ? '0 : cur_q + 1'b1;
    stat   = (cur_q >= G0_END) ? grp_s[1] : grp_s[0];
    done_w = armed_q && !stat;
    tmo_w  = (cnt_q == TMO_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cur_q    <= '0;
      ptr_q    <= '0;
      go_q     <= 1'b0;
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      oc_q     <= '0;
      sel_n_q  <= '1;
      res_stb  <= 1'b0;
      res_ch   <= '0;
      res_data <= '0;
      res_err  <= 1'b0;
    end else begin
      res_stb <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (enable) begin
            cur_q          <= ptr_q;
            sel_n_q[ptr_q] <= 1'b0;
            cnt_q          <= '0;
            armed_q        <= 1'b0;
            state_q        <= ST_CONV;
          end
        end
        ST_CONV: begin
          cnt_q <= cnt_q + 1'b1;
          if (stat) armed_q <= 1'b1;
          if (done_w) begin
            state_q <= ST_OVL;
            oc_q    <= '0;
            go_q    <= enable;
            if (enable) sel_n_q[nxt_ch] <= 1'b0;
          end else if (tmo_w) begin
            res_stb        <= 1'b1;
            res_ch         <= cur_q;
            res_data       <= '0;
            res_err        <= 1'b1;
            sel_n_q[cur_q] <= 1'b1;
            armed_q        <= 1'b0;
            cnt_q          <= '0;
            ptr_q          <= nxt_ch;
            if (enable) begin
              sel_n_q[nxt_ch] <= 1'b0;
              cur_q           <= nxt_ch;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_OVL: begin
          oc_q <= oc_q + 1'b1;
          if (oc_q == CAP_LAST) begin
            res_stb        <= 1'b1;
            res_ch         <= cur_q;
            res_data       <= bus_data;
            res_err        <= 1'b0;
            sel_n_q[cur_q] <= 1'b1;
            armed_q        <= 1'b0;
            ptr_q          <= nxt_ch;
            if (go_q) begin
              cur_q   <= nxt_ch;
              cnt_q   <= CNT_OVL;
              state_q <= ST_CONV;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sel_n = sel_n_q;

  // Checker state: overlap run length and last reported channel
  logic [$clog2(CLEAR_DL + 2)-1:0] ovl_run_q;
  logic [CH_W-1:0] last_ch_q;
  logic            seen_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      ovl_run_q <= '0;
      last_ch_q <= '0;
      seen_q    <= 1'b0;
    end else begin
      if ($countones(~sel_n_q) == 2) ovl_run_q <= ovl_run_q + 1'b1;
      else                           ovl_run_q <= '0;
      if (res_stb) begin
        last_ch_q <= res_ch;
        seen_q    <= 1'b1;
      end
    end
  end

  p_two_low_max_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(~sel_n_q) <= 2);

  p_conv_single_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV) |-> ($countones(~sel_n_q) == 1));

  p_clear_deadline_r4: assert property (@(posedge clk) disable iff (rst)
    ovl_run_q < CLEAR_DL);

  p_rr_order_r3: assert property (@(posedge clk) disable iff (rst)
    (res_stb && seen_q) |-> (res_ch == ((last_ch_q == LAST_CH) ? '0 : last_ch_q + 1'b1)));

  p_idle_blank_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (&sel_n_q));

  p_err_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (res_stb && res_err) |-> (res_data == '0));
endmodule

// File: rtl/mcs_regfile.sv
module mcs_regfile #(
  parameter int NUM_CH = 10,
  parameter int DATA_W = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_err,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_err
);
  logic [DATA_W-1:0] mem [NUM_CH];
  logic [NUM_CH-1:0] vld_q, err_q;

  // Data array without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ch] <= wr_data;
    rd_data <= mem[rd_ch];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      err_q    <= '0;
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
    end else begin
      if (wr_en) begin
        vld_q[wr_ch] <= !wr_err;
        err_q[wr_ch] <= wr_err;
      end
      rd_valid <= vld_q[rd_ch];
      rd_err   <= err_q[rd_ch];
    end
  end

  p_flag_update_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (vld_q[$past(wr_ch)] == !$past(wr_err)));
endmodule

// File: rtl/mcs_seq.sv
module mcs_seq #(
  parameter int NUM_CH      = 10,
  parameter int DATA_W      = 8,
  parameter int GRP0_SIZE   = 6,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT     = 200,
  parameter int CAP_DLY     = 30,
  parameter int CLEAR_DL    = 750,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [1:0]        grp_rdy_n,
  input  logic [DATA_W-1:0] bus_data,
  output logic [NUM_CH-1:0] sel_n,
  output logic              res_stb,
  output logic [CH_W-1:0]   res_ch,
  output logic [DATA_W-1:0] res_data,
  output logic              res_err,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_err
);
  logic [1:0] grp_s;

  mcs_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(grp_rdy_n), .q(grp_s)
  );

  mcs_ctrl #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .GRP0_SIZE(GRP0_SIZE),
    .TIMEOUT(TIMEOUT), .CAP_DLY(CAP_DLY), .CLEAR_DL(CLEAR_DL)
  ) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .grp_s(grp_s),
    .bus_data(bus_data), .sel_n(sel_n), .res_stb(res_stb),
    .res_ch(res_ch), .res_data(res_data), .res_err(res_err)
  );

  mcs_regfile #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst(rst), .wr_en(res_stb), .wr_ch(res_ch),
    .wr_data(res_data), .wr_err(res_err), .rd_ch(rd_ch),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_err(rd_err)
  );
endmodule

// File: tb/mcs_seq_test.sv
module mcs_seq_test;
  localparam int NUM_CH = 10;
  localparam int DATA_W = 8;
  localparam int G0     = 6;
  localparam int TMO    = 200;
  localparam int CAPD   = 30;
  localparam int CH_W   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [1:0] grp_rdy_n;
  logic [DATA_W-1:0] bus_data;
  logic [NUM_CH-1:0] sel_n;
  logic res_stb, res_err, rd_valid, rd_err;
  logic [CH_W-1:0] res_ch;
  logic [CH_W-1:0] rd_ch = '0;
  logic [DATA_W-1:0] res_data, rd_data;

  always #10 clk = ~clk;

  mcs_seq uut (
    .clk(clk), .rst(rst), .enable(enable), .grp_rdy_n(grp_rdy_n),
    .bus_data(bus_data), .sel_n(sel_n), .res_stb(res_stb), .res_ch(res_ch),
    .res_data(res_data), .res_err(res_err), .rd_ch(rd_ch), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_err(rd_err)
  );

  int n_cmp = 0, n_bad = 0, popped = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit is_dead(input int ch);
    return (ch == 3) || (ch == 8);
  endfunction
  function automatic logic [7:0] val_of(input int ch, input int v);
    return 8'((ch * 37 + v * 11 + 5) & 255);
  endfunction

  // Converter models
  int  cnt_c[NUM_CH], dly_c[NUM_CH], rel_c[NUM_CH], vis_c[NUM_CH], len_c[NUM_CH];
  bit  busy_c[NUM_CH], drv_c[NUM_CH], done_c[NUM_CH], prev_c[NUM_CH];
  bit  dr_n_c[NUM_CH];
  logic [7:0] dat_c[NUM_CH];
  int  ndrv;

  always @(negedge clk) begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (rst) begin
        cnt_c[ch] = 0; dly_c[ch] = 0; rel_c[ch] = 0; vis_c[ch] = 0; len_c[ch] = 0;
        busy_c[ch] = 0; drv_c[ch] = 0; done_c[ch] = 0; prev_c[ch] = 0;
        dr_n_c[ch] = 1; dat_c[ch] = '0;
      end else begin
        if (!sel_n[ch] && !prev_c[ch]) begin
          busy_c[ch] = 1; cnt_c[ch] = 48 + 3 * ch; vis_c[ch]++;
          dat_c[ch] = val_of(ch, vis_c[ch]); len_c[ch] = 0; done_c[ch] = 0;
        end
        if (sel_n[ch]) begin
          if (prev_c[ch]) begin
            if (is_dead(ch)) chk(len_c[ch] == TMO, "R7", "select length of silent channel", len_c[ch], TMO);
            else chk(done_c[ch], "R5", "released before completion", 0, 1);
          end
          busy_c[ch] = 0; drv_c[ch] = 0; dly_c[ch] = 0;
          if (!dr_n_c[ch] && rel_c[ch] == 0) rel_c[ch] = 5;
        end else begin
          len_c[ch]++;
          if (busy_c[ch]) begin
            cnt_c[ch]--;
            if (cnt_c[ch] == 0) begin
              busy_c[ch] = 0;
              if (!is_dead(ch)) begin dr_n_c[ch] = 0; dly_c[ch] = 10; done_c[ch] = 1; end
            end
          end else if (dly_c[ch] > 0) begin
            dly_c[ch]--;
            if (dly_c[ch] == 0) drv_c[ch] = 1;
          end
        end
        if (rel_c[ch] > 0) begin
          rel_c[ch]--;
          if (rel_c[ch] == 0) dr_n_c[ch] = 1;
        end
        prev_c[ch] = !sel_n[ch];
      end
    end
  end

  always_comb begin
    grp_rdy_n = 2'b11;
    bus_data  = '0;
    ndrv      = 0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (!dr_n_c[ch]) begin
        if (ch < G0) grp_rdy_n[0] = 1'b0;
        else         grp_rdy_n[1] = 1'b0;
      end
      if (drv_c[ch]) begin
        bus_data = bus_data | dat_c[ch];
        ndrv++;
      end
    end
  end

  // Select-line and bus checks
  int ovl_run = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if ($countones(~sel_n) > 2) chk(0, "R2", "select lines low", $countones(~sel_n), 2);
      if (ndrv > 1) chk(0, "R2", "bus drivers", ndrv, 1);
      if ($countones(~sel_n) == 2) ovl_run++;
      else if (ovl_run > 0) begin
        chk(ovl_run == CAPD + 1, "R4", "overlap length", ovl_run, CAPD + 1);
        ovl_run = 0;
      end
    end
  end

  // Scoreboard
  typedef struct { int ch; bit err; int data; } exp_t;
  exp_t q[$];
  int nxt_ch = 0;
  int dvis[NUM_CH];
  bit e_vld[NUM_CH], e_err[NUM_CH];
  int e_dat[NUM_CH];

  task automatic push_items(input int n);
    for (int i = 0; i < n; i++) begin
      exp_t it;
      dvis[nxt_ch]++;
      it.ch   = nxt_ch;
      it.err  = is_dead(nxt_ch);
      it.data = it.err ? 0 : int'(val_of(nxt_ch, dvis[nxt_ch]));
      e_vld[nxt_ch] = !it.err;
      e_err[nxt_ch] = it.err;
      if (!it.err) e_dat[nxt_ch] = it.data;
      q.push_back(it);
      nxt_ch = (nxt_ch + 1) % NUM_CH;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && res_stb) begin
      if (q.size() == 0) begin
        chk(0, "R8", "unexpected result on channel", int'(res_ch), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(int'(res_ch) == e.ch, "R3", "result channel", int'(res_ch), e.ch);
        chk(res_err == e.err, "R7", "error flag", int'(res_err), int'(e.err));
        chk(int'(res_data) == e.data, e.err ? "R7" : "R6", "result data", int'(res_data), e.data);
      end
      popped++;
    end
  end

  task automatic check_rf(input string tag);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      @(negedge clk) rd_ch = CH_W'(ch);
      @(negedge clk);
      chk(rd_valid == e_vld[ch], "R9", {tag, " valid flag"}, int'(rd_valid), int'(e_vld[ch]));
      chk(rd_err == e_err[ch], "R9", {tag, " error flag"}, int'(rd_err), int'(e_err[ch]));
      if (e_vld[ch]) chk(int'(rd_data) == e_dat[ch], "R9", {tag, " stored data"}, int'(rd_data), e_dat[ch]);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    for (int ch = 0; ch < NUM_CH; ch++) begin dvis[ch] = 0; e_vld[ch] = 0; e_err[ch] = 0; e_dat[ch] = 0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sel_n == '1, "R1", "select lines after reset", int'(sel_n), 1023);
    chk(res_stb == 1'b0, "R1", "strobe after reset", int'(res_stb), 0);
    chk(rd_valid == 1'b0 && rd_err == 1'b0, "R1", "flags after reset", int'({rd_valid, rd_err}), 0);
    repeat (20) @(negedge clk);
    chk(sel_n == '1, "R8", "idle with enable low", int'(sel_n), 1023);

    // Phase 1: two and a half rounds, stop after the 24th result
    push_items(25);
    enable = 1'b1;
    wait (popped == 24);
    @(negedge clk) enable = 1'b0;
    wait (popped == 25);
    repeat (300) @(negedge clk);
    chk(sel_n == '1, "R8", "blank after stop", int'(sel_n), 1023);
    chk(q.size() == 0, "R8", "expected items left", q.size(), 0);
    check_rf("phase1");

    // Phase 2: resume from channel 5
    push_items(7);
    @(negedge clk) enable = 1'b1;
    wait (popped == 31);
    @(negedge clk) enable = 1'b0;
    wait (popped == 32);
    repeat (300) @(negedge clk);
    chk(sel_n == '1, "R8", "blank after second stop", int'(sel_n), 1023);
    chk(q.size() == 0, "R8", "expected items left", q.size(), 0);
    check_rf("phase2");
    summary();
  end
endmodule